// File: doc/BRIEF.md
# Bidirectional Row Scan Shift Register

This block holds the row-select pattern of a matrix panel's scan side. A serial token enters at one end of a chain of stages and moves one stage per scan pulse. Each stage drives one row output. A direction input chooses which end is the entry, and a split input chooses between one long chain and two half-length chains that advance side by side.

The scan pulse `lp_i` is sampled by the system clock. A shift happens on the first clock edge that sees `lp_i` low after it was high. Each of the two end pins is modelled as an input, an output and an output enable. The pin at the entry end takes data in. The pin at the far end drives out the last stage. While the blanking input is low, the chain is cleared and the rows are held low. After blanking is released, the rows stay low until the next scan pulse has been taken.

Top module: `row_scan_shifter`

## Requirements
- R1: After reset, all `row_o` bits, all stages and both serial outputs are 0.
- R2: The chain changes only on a scan-pulse falling edge, which is a clock edge where `lp_i` is 0 and was 1 at the previous clock edge. Each such edge moves the data by exactly one stage. At every other clock edge all stages hold their values.
- R3: Single chain, `dir_i`=0: stage k takes stage k+1, and the top stage (`row_o[STAGES-1]`) takes `end_b_i`.
- R4: Single chain, `dir_i`=1: stage k takes stage k-1, and the bottom stage (`row_o[0]`) takes `end_a_i`.
- R5: Split chains, `dir_i`=1: `row_o[0]` takes `end_a_i` and `row_o[STAGES/2]` takes `mid_i`. No data crosses from `row_o[STAGES/2-1]` into the upper half.
- R6: Split chains, `dir_i`=0: `row_o[STAGES-1]` takes `end_b_i` and `row_o[STAGES/2-1]` takes `mid_i`. No data crosses from `row_o[STAGES/2]` into the lower half.
- R7: With `dir_i`=0, `end_a_oe_o`=1, `end_b_oe_o`=0, `end_a_o` equals stage `row_o[0]` and `end_b_o`=0. With `dir_i`=1 the roles swap: `end_b_oe_o`=1, `end_a_oe_o`=0, `end_b_o` equals stage `row_o[STAGES-1]` and `end_a_o`=0. The input of the driving pin is ignored.
- R8: At every clock edge where `blank_ni` is 0, every stage is cleared and scan pulses are not taken. `row_o` reads all zeros.
- R9: After `blank_ni` returns to 1, `row_o` stays all zeros until a scan-pulse falling edge is taken. From then on, `row_o` shows the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lp_i | input | 1 | Scan pulse; a shift happens on its falling edge |
| dir_i | input | 1 | 0: shift toward stage 0; 1: shift toward the top stage |
| split_i | input | 1 | 0: one chain; 1: two half chains |
| blank_ni | input | 1 | Active-low blanking and clear |
| mid_i | input | 1 | Serial input of the second chain in split mode |
| end_a_i | input | 1 | Bottom-end pin, input side |
| end_a_o | output | 1 | Bottom-end pin, output side |
| end_a_oe_o | output | 1 | Bottom-end pin drive enable |
| end_b_i | input | 1 | Top-end pin, input side |
| end_b_o | output | 1 | Top-end pin, output side |
| end_b_oe_o | output | 1 | Top-end pin drive enable |
| row_o | output | STAGES | Row outputs, bit k is stage k |

## Verification
The shift assertions assume that `dir_i` and `split_i` are stable at the clock edge where a scan falling edge is taken. They also assume that `lp_i` is synchronous to `clk_i` and stays at each level for at least one clock. The stimulus changes every input only shortly after a rising clock edge. It holds `lp_i` high for two clocks and low for two clocks. It changes direction and split mode only between pulses, and never while a shift is due. The blanking stimulus is applied both in the middle of a pulse train and on its own, so that the clear and the held-low window can be observed at the rows.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic {
    SHIFT_DN = 1'b0,
    SHIFT_UP = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/scan_edge.sv
module scan_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_i,
  output logic fall_o
);
  logic lp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_q <= 1'b0;
    else         lp_q <= lp_i;
  end

  assign fall_o = lp_q & ~lp_i;
endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import row_scan_pkg::*;
#(
  parameter int unsigned STAGES = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              clear_i,
  input  shift_dir_e        dir_i,
  input  logic              split_i,
  input  logic              ser_a_i,
  input  logic              ser_b_i,
  input  logic              mid_i,
  output logic [STAGES-1:0] chain_o
);
  localparam int unsigned HALF = STAGES / 2;

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic up_src, dn_src, stage_q;

    if (i == 0) begin : g_up_end
      assign up_src = ser_a_i;
    end else if (i == HALF) begin : g_up_mid
      assign up_src = split_i ? mid_i : chain_q[i-1];
    end else begin : g_up_mid_no
      assign up_src = chain_q[i-1];
    end

    if (i == STAGES - 1) begin : g_dn_end
      assign dn_src = ser_b_i;
    end else if (i == HALF - 1) begin : g_dn_mid
      assign dn_src = split_i ? mid_i : chain_q[i+1];
    end else begin : g_dn_mid_no
      assign dn_src = chain_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q <= 1'b0;
      else if (clear_i) stage_q <= 1'b0;
      else if (shift_i) stage_q <= (dir_i == SHIFT_UP) ? up_src : dn_src;
    end

    assign chain_q[i] = stage_q;
  end

  assign chain_o = chain_q;

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !shift_i) |=> $stable(chain_q));

  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (chain_q == '0));

  // R4
  up_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && shift_i && dir_i == SHIFT_UP && !split_i) |=>
      (chain_q[STAGES-1:1] == $past(chain_q[STAGES-2:0])) && (chain_q[0] == $past(ser_a_i)));

  // R3
  dn_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && shift_i && dir_i == SHIFT_DN && !split_i) |=>
      (chain_q[STAGES-2:0] == $past(chain_q[STAGES-1:1])) && (chain_q[STAGES-1] == $past(ser_b_i)));

  // R5
  up_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && shift_i && dir_i == SHIFT_UP && split_i) |=>
      (chain_q[HALF] == $past(mid_i)) && (chain_q[0] == $past(ser_a_i)));

  // R6
  dn_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && shift_i && dir_i == SHIFT_DN && split_i) |=>
      (chain_q[HALF-1] == $past(mid_i)) && (chain_q[STAGES-1] == $past(ser_b_i)));
endmodule

// File: rtl/scan_ends.sv
module scan_ends
  import row_scan_pkg::*;
(
  input  shift_dir_e dir_i,
  input  logic       low_stage_i,
  input  logic       high_stage_i,
  output logic       end_a_o,
  output logic       end_a_oe_o,
  output logic       end_b_o,
  output logic       end_b_oe_o
);
  always_comb begin
    end_a_oe_o = (dir_i == SHIFT_DN);
    end_b_oe_o = (dir_i == SHIFT_UP);
    end_a_o    = end_a_oe_o ? low_stage_i  : 1'b0;
    end_b_o    = end_b_oe_o ? high_stage_i : 1'b0;
  end
endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter
  import row_scan_pkg::*;
#(
  parameter int unsigned STAGES = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lp_i,
  input  logic              dir_i,
  input  logic              split_i,
  input  logic              blank_ni,
  input  logic              mid_i,
  input  logic              end_a_i,
  output logic              end_a_o,
  output logic              end_a_oe_o,
  input  logic              end_b_i,
  output logic              end_b_o,
  output logic              end_b_oe_o,
  output logic [STAGES-1:0] row_o
);
  shift_dir_e        dir;
  logic              lp_fall, shift, clear, shown_q;
  logic [STAGES-1:0] chain;

  assign dir   = shift_dir_e'(dir_i);
  assign clear = ~blank_ni;
  assign shift = lp_fall & blank_ni;

  scan_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lp_i   (lp_i),
    .fall_o (lp_fall)
  );

  scan_chain #(.STAGES(STAGES)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .clear_i (clear),
    .dir_i   (dir),
    .split_i (split_i),
    .ser_a_i (end_a_i),
    .ser_b_i (end_b_i),
    .mid_i   (mid_i),
    .chain_o (chain)
  );

  scan_ends u_ends (
    .dir_i        (dir),
    .low_stage_i  (chain[0]),
    .high_stage_i (chain[STAGES-1]),
    .end_a_o      (end_a_o),
    .end_a_oe_o   (end_a_oe_o),
    .end_b_o      (end_b_o),
    .end_b_oe_o   (end_b_oe_o)
  );

  // rows stay low after blanking until fresh data is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    shown_q <= 1'b0;
    else if (clear) shown_q <= 1'b0;
    else if (shift) shown_q <= 1'b1;
  end

  assign row_o = shown_q ? chain : '0;

  // R8
  blank_rows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |=> (row_o == '0));

  // R9
  quiet_rows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && !lp_fall && row_o == '0) |=> (row_o == '0));
endmodule

// File: tb/row_scan_shifter_bench.sv
`timescale 1ns/1ps
module row_scan_shifter_bench;
  localparam int N = 160;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lp = 1'b0, dir = 1'b0, split = 1'b0, blank_n = 1'b1, mid = 1'b0, ea = 1'b0, eb = 1'b0;
  logic ea_o, ea_oe, eb_o, eb_oe;
  logic [N-1:0] row;

  always #4 clk = ~clk;

  row_scan_shifter #(.STAGES(N)) u_row_scan_shifter (
    .clk_i(clk), .rst_ni(rst_ni), .lp_i(lp), .dir_i(dir), .split_i(split),
    .blank_ni(blank_n), .mid_i(mid), .end_a_i(ea), .end_a_o(ea_o), .end_a_oe_o(ea_oe),
    .end_b_i(eb), .end_b_o(eb_o), .end_b_oe_o(eb_oe), .row_o(row)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference
  bit m[N];
  bit lp_prev = 1'b0, shown = 1'b0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m[k]) m[k] = 1'b0;
      lp_prev = 1'b0;
      shown = 1'b0;
    end else begin
      bit fall;
      bit old[N];
      fall = lp_prev && !lp;
      lp_prev = lp;
      if (!blank_n) begin
        foreach (m[k]) m[k] = 1'b0;
        shown = 1'b0;
      end else if (fall) begin
        old = m;
        shown = 1'b1;
        for (int k = 0; k < N; k++) begin
          if (dir) m[k] = (k == 0) ? ea : ((split && k == H) ? mid : old[k-1]);
          else     m[k] = (k == N-1) ? eb : ((split && k == H-1) ? mid : old[k+1]);
        end
      end
    end
  end

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [N-1:0] er;
      for (int k = 0; k < N; k++) er[k] = shown ? m[k] : 1'b0;
      check(cur_req, row, er, "row");
      check("R7", {ea_oe, eb_oe, ea_o, eb_o},
            {!dir, dir, (!dir) ? m[0] : 1'b0, dir ? m[N-1] : 1'b0}, "ends");
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic pulse(bit a, bit b, bit md);
    ea = a; eb = b; mid = md;
    lp = 1'b1; step(); step();
    lp = 1'b0; step(); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1
    check("R1", row, '0, "reset rows");
    check("R1", {ea_o, eb_o}, '0, "reset ends");

    cur_req = "R4"; dir = 1'b1; split = 1'b0;
    for (int i = 0; i < N + 10; i++) pulse($urandom_range(0, 1), $urandom_range(0, 1), 1'b0);

    cur_req = "R2";
    for (int i = 0; i < 12; i++) begin ea = ~ea; eb = ~eb; mid = ~mid; step(); end

    cur_req = "R3"; dir = 1'b0;
    for (int i = 0; i < N + 10; i++) pulse($urandom_range(0, 1), $urandom_range(0, 1), 1'b1);

    cur_req = "R5"; dir = 1'b1; split = 1'b1;
    for (int i = 0; i < H + 20; i++) pulse($urandom_range(0, 1), 1'b1, $urandom_range(0, 1));

    cur_req = "R6"; dir = 1'b0;
    for (int i = 0; i < H + 20; i++) pulse(1'b1, $urandom_range(0, 1), $urandom_range(0, 1));

    cur_req = "R8"; split = 1'b0; dir = 1'b1;
    for (int i = 0; i < 8; i++) pulse(1'b1, 1'b1, 1'b1);
    blank_n = 1'b0;
    for (int i = 0; i < 4; i++) pulse(1'b1, 1'b1, 1'b1);
    check("R8", row, '0, "rows while blanked");

    cur_req = "R9"; blank_n = 1'b1;
    for (int i = 0; i < 6; i++) step();
    check("R9", row, '0, "rows before first pulse");
    pulse(1'b1, 1'b0, 1'b0);
    check("R9", row, {{(N-1){1'b0}}, 1'b1}, "rows after first pulse");
    for (int i = 0; i < 20; i++) pulse($urandom_range(0, 1), 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule